// File: doc/BRIEF.md
# Seven-Switch Null-Vector PWM Gate Logic

This block produces the gate drive for a three-phase bridge of six switches plus a seventh auxiliary switch in a step up/down rectifier. A symmetric triangular carrier is generated internally from a programmable half-period. Each of the three signed phase references is compared against this carrier, and only the sign of each comparison is kept. The three signs together choose one of seven switching modes. Six of the modes are the mixed-sign cases. The seventh is the case where all three signs agree: it closes every bridge switch and opens the auxiliary switch, so that the DC side charges as in a SEPIC stage.

Each bridge leg conducts through one of its two switches in every mixed mode. A short overlap between modes only means the bridge passes briefly through the all-closed state, which is a legal operating state. The block therefore needs no dead-time insertion and no interlock. The gate word and a 3-bit mode code are both registered, and the mode code is there for observation.

Top module: `pwm7_gate_logic`

## Requirements
- R1: While reset is asserted, all seven gate bits are 0 (all switches open) and the mode code is 0.
- R2: The carrier counter steps once per clock through 0,1,…,H,H-1,…,1,0,1,… where H is `half_i`, and the carrier value is 2·count−H. If H is 0, the counter holds 0.
- R3: Any reference word above +H is treated as +H, and any below −H is treated as −H.
- R4: Phase k is positive when carrier − reference_k ≥ 0. A difference of exactly zero counts as positive.
- R5: Writing the signs of phases 1,2,3 as p1p2p3 (1 = positive), the mode code is 110→1, 101→2, 100→3, 011→4, 010→5, 001→6, and 111 or 000→7.
- R6: Gate bit k−1 drives switch Sk. The modes close these switches: 1 closes S1,S2,S6,S7; 2 closes S1,S3,S5,S7; 3 closes S1,S5,S6,S7; 4 closes S2,S3,S4,S7; 5 closes S2,S4,S6,S7; 6 closes S3,S4,S5,S7. Every other switch is open, so exactly four are closed.
- R7: In mode 7, S1 to S6 are closed and S7 is open.
- R8: The gate word and the mode code on the outputs come from the counter value and the reference inputs present just before the latest rising clock edge.
- R9: When the counter is at H, the outputs after the next edge show mode 7. When the counter is at 0 and all three references are greater than −H, the outputs after the next edge also show mode 7. These are the two null intervals of each period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| half_i | input | CW | Carrier half-period H in clocks |
| ref1_i | input | RW | Phase 1 reference, signed, in carrier units |
| ref2_i | input | RW | Phase 2 reference, signed |
| ref3_i | input | RW | Phase 3 reference, signed |
| gate_o | output | 7 | Switch gates, bit k−1 drives Sk, 1 = closed |
| mode_o | output | 3 | Active mode code, 0 only in reset |

## Verification
The hardest case to reach from the ports is a difference of exactly zero while the carrier is at one of its extremes or between them. In that case the zero-counts-positive rule and the reference clamp together decide the mode. The bench holds each triplet of references for a whole carrier period and sweeps every triplet drawn from −H−2 to H+2. As a result, every carrier position meets every reference value, including the out-of-range values that clamp to exactly ±H. The half-period is also changed in mid-count and set to zero.

// File: rtl/pwm7_pkg.sv
package pwm7_pkg;
  localparam int NSW = 7;
  typedef logic [2:0] mode_t;
  localparam mode_t MODE_RESET = 3'd0;
  localparam mode_t MODE_NULL  = 3'd7;
endpackage

// File: rtl/pwm7_carrier.sv
module pwm7_carrier #(
  parameter int CW = 10
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [CW-1:0]        half_i,
  output logic [CW-1:0]        cnt_o,
  output logic signed [CW+1:0] car_o
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          up_q, up_d;

  always_comb begin
    cnt_d = cnt_q;
    up_d  = up_q;
    if (half_i == '0) begin
      cnt_d = '0;
      up_d  = 1'b1;
    end else if (up_q) begin
      if (cnt_q >= half_i) begin
        cnt_d = cnt_q - 1'b1;
        up_d  = 1'b0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end else begin
      if (cnt_q == '0) begin
        cnt_d = {{(CW-1){1'b0}}, 1'b1};
        up_d  = 1'b1;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
    end else begin
      cnt_q <= cnt_d;
      up_q  <= up_d;
    end
  end

  assign cnt_o = cnt_q;
  assign car_o = $signed({1'b0, cnt_q, 1'b0}) - $signed({2'b00, half_i});
endmodule

// File: rtl/pwm7_sign.sv
module pwm7_sign #(
  parameter int CW = 10,
  parameter int RW = 12
) (
  input  logic signed [CW+1:0] car_i,
  input  logic [CW-1:0]        half_i,
  input  logic signed [RW-1:0] ref_i,
  output logic                 pos_o
);
  localparam int XW = ((RW > CW + 2) ? RW : CW + 2) + 1;

  logic signed [XW-1:0] car_x, ref_x, hi_x, lo_x, lim_x, diff_x;

  assign car_x = {{(XW-CW-2){car_i[CW+1]}}, car_i};
  assign ref_x = {{(XW-RW){ref_i[RW-1]}}, ref_i};
  assign hi_x  = {{(XW-CW){1'b0}}, half_i};
  assign lo_x  = -hi_x;

  always_comb begin
    if (ref_x > hi_x)      lim_x = hi_x;
    else if (ref_x < lo_x) lim_x = lo_x;
    else                   lim_x = ref_x;
  end

  assign diff_x = car_x - lim_x;
  assign pos_o  = ~diff_x[XW-1];
endmodule

// File: rtl/pwm7_decode.sv
module pwm7_decode
  import pwm7_pkg::*;
(
  input  logic [2:0]     pos_i,
  output logic [NSW-1:0] gate_o,
  output mode_t          mode_o
);
  logic all_eq;
  assign all_eq = (&pos_i) | ~(|pos_i);

  genvar k;
  generate
    for (k = 0; k < 3; k++) begin : g_leg
      assign gate_o[k]   = pos_i[2-k] | all_eq;
      assign gate_o[k+3] = ~pos_i[2-k] | all_eq;
    end
  endgenerate
  assign gate_o[6] = ~all_eq;

  always_comb begin
    case (pos_i)
      3'b110:  mode_o = 3'd1;
      3'b101:  mode_o = 3'd2;
      3'b100:  mode_o = 3'd3;
      3'b011:  mode_o = 3'd4;
      3'b010:  mode_o = 3'd5;
      3'b001:  mode_o = 3'd6;
      default: mode_o = MODE_NULL;
    endcase
  end
endmodule

// File: rtl/pwm7_gate_logic.sv
module pwm7_gate_logic
  import pwm7_pkg::*;
#(
  parameter int CW = 10,
  parameter int RW = 12
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [CW-1:0]        half_i,
  input  logic signed [RW-1:0] ref1_i,
  input  logic signed [RW-1:0] ref2_i,
  input  logic signed [RW-1:0] ref3_i,
  output logic [6:0]           gate_o,
  output logic [2:0]           mode_o
);
  logic [CW-1:0]        cnt;
  logic signed [CW+1:0] car;
  logic [2:0]           pos;
  logic [RW-1:0]        refs [3];
  logic [NSW-1:0]       gate_d, gate_q;
  mode_t                mode_d, mode_q;

  assign refs[0] = ref1_i;
  assign refs[1] = ref2_i;
  assign refs[2] = ref3_i;

  pwm7_carrier #(.CW(CW)) u_car (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .half_i (half_i),
    .cnt_o  (cnt),
    .car_o  (car)
  );

  genvar p;
  generate
    for (p = 0; p < 3; p++) begin : g_ph
      pwm7_sign #(.CW(CW), .RW(RW)) u_sign (
        .car_i  (car),
        .half_i (half_i),
        .ref_i  ($signed(refs[p])),
        .pos_o  (pos[2-p])
      );
    end
  endgenerate

  pwm7_decode u_dec (
    .pos_i  (pos),
    .gate_o (gate_d),
    .mode_o (mode_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gate_q <= '0;
      mode_q <= MODE_RESET;
    end else begin
      gate_q <= gate_d;
      mode_q <= mode_d;
    end
  end

  assign gate_o = gate_q;
  assign mode_o = mode_q;
endmodule

// File: rtl/pwm7_gate_logic_chk.sv
module pwm7_gate_logic_chk #(
  parameter int CW = 10
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [CW-1:0] half_i,
  input logic [CW-1:0] cnt,
  input logic [6:0]    gate_o,
  input logic [2:0]    mode_o
);
  AST_NULL_PATTERN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 3'd7) |-> (gate_o == 7'b0111111)); // R7

  AST_MIXED_FOUR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o != 3'd7 && mode_o != 3'd0) |-> ($countones(gate_o) == 4 && gate_o[6])); // R6

  AST_LEG_COMPL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_o[6] |-> ((gate_o[0] ^ gate_o[3]) && (gate_o[1] ^ gate_o[4]) && (gate_o[2] ^ gate_o[5]))); // R6

  AST_MODE_LIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> (mode_o != 3'd0)); // R5

  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $stable(half_i) && $past(cnt) <= $past(half_i)) |-> (cnt <= half_i)); // R2

  AST_TOP_NULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (half_i != '0 && cnt == half_i) |=> (mode_o == 3'd7)); // R9
endmodule

bind pwm7_gate_logic pwm7_gate_logic_chk #(.CW(CW)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .half_i (half_i),
  .cnt    (cnt),
  .gate_o (gate_o),
  .mode_o (mode_o)
);

// File: tb/pwm7_gate_logic_bench.sv
module pwm7_gate_logic_bench;
  localparam int CW = 4;
  localparam int RW = 6;

  logic                 clk;
  logic                 rst_n;
  logic [CW-1:0]        half;
  logic signed [RW-1:0] r1, r2, r3;
  logic [6:0]           gate;
  logic [2:0]           mode;

  int checks = 0;
  int failures = 0;
  int m_cnt = 0;
  bit m_up = 1'b1;
  bit done = 1'b0;

  pwm7_gate_logic #(.CW(CW), .RW(RW)) u_pwm7_gate_logic (
    .clk_i (clk), .rst_ni (rst_n), .half_i (half),
    .ref1_i (r1), .ref2_i (r2), .ref3_i (r3),
    .gate_o (gate), .mode_o (mode)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic int clampv(input int v, input int h);
    if (v > h) return h;
    if (v < -h) return -h;
    return v;
  endfunction

  function automatic logic [6:0] gate_of(input int md);
    case (md)
      1: return 7'b1100011;
      2: return 7'b1010101;
      3: return 7'b1110001;
      4: return 7'b1001110;
      5: return 7'b1101010;
      6: return 7'b1011100;
      7: return 7'b0111111;
      default: return 7'b0000000;
    endcase
  endfunction

  task automatic model_step(input int h);
    if (h == 0) begin m_cnt = 0; m_up = 1'b1; end
    else if (m_up) begin
      if (m_cnt >= h) begin m_cnt = m_cnt - 1; m_up = 1'b0; end
      else m_cnt = m_cnt + 1;
    end else begin
      if (m_cnt == 0) begin m_cnt = 1; m_up = 1'b1; end
      else m_cnt = m_cnt - 1;
    end
  endtask

  // Entered at a negedge: apply stimulus, predict, clock, compare.
  task automatic step(input int h, input int a, input int b, input int c);
    int car, d1, d2, d3, md;
    bit p1, p2, p3, any_zero, any_clamp, at_top, at_bot;
    logic [6:0] eg;
    half = h[CW-1:0];
    r1 = a[RW-1:0]; r2 = b[RW-1:0]; r3 = c[RW-1:0];
    car = 2 * m_cnt - h;
    d1 = car - clampv(a, h); d2 = car - clampv(b, h); d3 = car - clampv(c, h);
    p1 = d1 >= 0; p2 = d2 >= 0; p3 = d3 >= 0;
    if (p1 == p2 && p2 == p3) md = 7;
    else if ( p1 &&  p2 && !p3) md = 1;
    else if ( p1 && !p2 &&  p3) md = 2;
    else if ( p1 && !p2 && !p3) md = 3;
    else if (!p1 &&  p2 &&  p3) md = 4;
    else if (!p1 &&  p2 && !p3) md = 5;
    else md = 6;
    eg = gate_of(md);
    any_zero = (d1 == 0) || (d2 == 0) || (d3 == 0);
    any_clamp = (a > h) || (a < -h) || (b > h) || (b < -h) || (c > h) || (c < -h);
    at_top = (h != 0) && (m_cnt == h);
    at_bot = (h != 0) && (m_cnt == 0) && (a > -h) && (b > -h) && (c > -h);
    @(posedge clk);
    model_step(h);
    @(negedge clk);
    checks++;
    if (gate !== eg || mode !== md[2:0]) begin
      failures++;
      $display("FAIL R5/R6/R7/R8%s%s%s%s h=%0d refs=%0d,%0d,%0d gate=%b mode=%0d expected gate=%b mode=%0d",
               any_zero ? " R4" : "", any_clamp ? " R3" : "",
               (at_top || at_bot) ? " R9" : "", (h == 0) ? " R2" : "",
               h, a, b, c, gate, mode, eg, md);
    end
  endtask

  initial begin
    rst_n = 1'b0; half = 4'd3; r1 = '0; r2 = '0; r3 = '0;
    repeat (3) @(negedge clk);
    checks++;
    if (gate !== 7'b0 || mode !== 3'd0) begin
      failures++;
      $display("FAIL R1 gate=%b mode=%0d expected gate=0000000 mode=0", gate, mode);
    end
    rst_n = 1'b1;
    m_cnt = 0; m_up = 1'b1;
    // R3 R4 R5 R6 R7 R8 R9: every reference triplet across a full carrier period
    for (int hs = 0; hs < 2; hs++) begin
      int h;
      h = (hs == 0) ? 3 : 5;
      for (int a = -h - 2; a <= h + 2; a++)
        for (int b = -h - 2; b <= h + 2; b++)
          for (int c = -h - 2; c <= h + 2; c++)
            for (int t = 0; t < 2 * h; t++)
              step(h, a, b, c);
    end
    // R2: half-period changes mid-count, then zero
    for (int t = 0; t < 40; t++) step(7, 2, -3, 0);
    for (int t = 0; t < 6; t++) step(2, 1, -1, 0);
    for (int t = 0; t < 8; t++) step(0, 3, -3, 1);
    for (int t = 0; t < 30; t++) step(6, -5, 4, 6);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired: actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule